// File: doc/BRIEF.md
# Host/MCU Byte Mailbox with Handshake Flags

This block passes single bytes between a host processor bus and a small microcontroller that sees the world through parallel ports. The host writes a command byte into an inbound latch. That write raises a "host wrote" flag and pulls the MCU interrupt low. The MCU picks up the byte from its bidirectional data port, and the block drives that port only when the MCU asks for it. A reply goes the other way. The MCU presents a byte on the data port and pulses a control bit, which captures the byte into an outbound latch and raises an "MCU wrote" flag. The host then collects the reply.

Both flags can be read at two places: on the MCU's control-port input bits, and in a host status register. The MCU control port also has level-sensitive bits that clear the inbound flag and capture a reply. The host side also holds an NMI request. An acknowledge read of a dedicated address clears it, and that read returns the system status byte.

A read flagged as a debugger access returns the same data as a normal read but changes no state. This applies to reads from either side.

Top module: `mcu_mailbox`

## Requirements
- R1: After reset, both handshake flags and the NMI are 0, `mcu_irq_n` is 1, and both latches hold 0x00.
- R2: A host write to address 0 loads `host_wdata` into the inbound latch, sets the host-wrote flag (`mcu_flags[0]`) and drives `mcu_irq_n` low, all visible one cycle later.
- R3: While `mcu_ctl[2]` is 1, the host-wrote flag and the interrupt clear at the next edge and `pa_oe` is 0. While `mcu_ctl[2]` is 0, `pa_oe` is 1 and `pa_out` carries the inbound latch.
- R4: An `mcu_cmd_rd` strobe with `mcu_dbg` 0 clears the host-wrote flag and leaves the interrupt unchanged. With `mcu_dbg` 1 it changes nothing.
- R5: While `mcu_ctl[3]` is 1, `pa_in` is captured into the outbound latch and the MCU-wrote flag (`mcu_flags[1]`) is set at each edge. While it is 0, the latch and flag are not touched.
- R6: A host read of address 0 returns the outbound latch in the same cycle. It clears the MCU-wrote flag unless `host_dbg` is 1.
- R7: A host read of address 1 returns a status byte whose bit 0 is the host-wrote flag and bit 1 is the MCU-wrote flag, with all other bits 0. The read has no side effect.
- R8: A `nmi_trig` pulse sets `host_nmi`. A host read of address 2 returns `sys_status` and clears `host_nmi` unless `host_dbg` is 1.
- R9: When a flag's set and clear events land in the same cycle, the flag ends up set. This covers a host write against `mcu_ctl[2]` or an MCU read, a capture against a reply read, and a trigger against an acknowledge.
- R10: Host writes to any address other than 0 are ignored. A host read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_dbg | input | 1 | Host read is a debugger access (no side effects) |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| sys_status | input | DATA_W | System status byte returned on acknowledge |
| nmi_trig | input | 1 | Sets the host NMI request |
| host_nmi | output | 1 | Host NMI request level |
| mcu_ctl | input | 4 | MCU control-port output bits |
| mcu_flags | output | 2 | Flags to MCU control-port inputs: [0] host wrote, [1] MCU wrote |
| mcu_cmd_rd | input | 1 | MCU command read strobe |
| mcu_dbg | input | 1 | MCU read is a debugger access |
| pa_in | input | DATA_W | Data port value driven by the MCU |
| pa_out | output | DATA_W | Data port value driven by the block |
| pa_oe | output | 1 | Block drives the data port |
| mcu_irq_n | output | 1 | Active-low MCU interrupt |

## Verification
The bench sweeps all 256 byte values in both directions and alternates between the two ways of clearing the inbound flag. A design that also cleared the interrupt on an MCU read, or that left the port driven while the clear bit is high, would show up on `mcu_irq_n` or `pa_oe`. Debug reads are issued against every flag and their result is read back at the ports; a design that let a debug read clear a flag would lose the pending command or NMI. Set/clear collisions are forced on every flag, and clear-priority logic would drop the new event. Writes to unused addresses are checked against the data-port contents.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADR_DATA = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_ACK  = 2;

  localparam int NFLAG   = 4;
  localparam int F_HOST  = 0;
  localparam int F_MCU   = 1;
  localparam int F_NMI   = 2;
  localparam int F_IRQ   = 3;

  localparam int CTL_CLR = 2;
  localparam int CTL_CAP = 3;
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q)); // R5
endmodule

// File: rtl/mbx_latch.sv
module mbx_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d))); // R2
  AST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q)); // R10
endmodule

// File: rtl/mcu_mailbox.sv
module mcu_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_dbg,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] sys_status,
  input  logic              nmi_trig,
  output logic              host_nmi,
  input  logic [3:0]        mcu_ctl,
  output logic [1:0]        mcu_flags,
  input  logic              mcu_cmd_rd,
  input  logic              mcu_dbg,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic              pa_oe,
  output logic              mcu_irq_n
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADR_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ADR_ACK);

  function automatic logic [DATA_W-1:0] pack_status(input logic hf, input logic mf);
    logic [DATA_W-1:0] s;
    s    = '0;
    s[0] = hf;
    s[1] = mf;
    return s;
  endfunction

  // named internal events
  logic cmd_wr, reply_rd, ack_rd, mcu_clr, mcu_cap, mcu_take;
  assign cmd_wr   = host_wr && (host_addr == A_DATA);
  assign reply_rd = host_rd && !host_dbg && (host_addr == A_DATA);
  assign ack_rd   = host_rd && !host_dbg && (host_addr == A_ACK);
  assign mcu_clr  = mcu_ctl[CTL_CLR];
  assign mcu_cap  = mcu_ctl[CTL_CAP];
  assign mcu_take = mcu_cmd_rd && !mcu_dbg;

  logic [NFLAG-1:0] set_v, clr_v, flag_q;
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_HOST] = cmd_wr;   clr_v[F_HOST] = mcu_clr || mcu_take;
    set_v[F_MCU]  = mcu_cap;  clr_v[F_MCU]  = reply_rd;
    set_v[F_NMI]  = nmi_trig; clr_v[F_NMI]  = ack_rd;
    set_v[F_IRQ]  = cmd_wr;   clr_v[F_IRQ]  = mcu_clr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    mbx_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_v[g]), .clr(clr_v[g]), .q(flag_q[g])
    );
  end

  logic [DATA_W-1:0] cmd_q, reply_q;
  mbx_latch #(.WIDTH(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ld(cmd_wr), .d(host_wdata), .q(cmd_q)
  );
  mbx_latch #(.WIDTH(DATA_W)) u_reply (
    .clk(clk), .rst_n(rst_n), .ld(mcu_cap), .d(pa_in), .q(reply_q)
  );

  assign mcu_flags = {flag_q[F_MCU], flag_q[F_HOST]};
  assign host_nmi  = flag_q[F_NMI];
  assign mcu_irq_n = ~flag_q[F_IRQ];
  assign pa_oe     = ~mcu_clr;
  assign pa_out    = cmd_q;

  always_comb begin
    unique case (host_addr)
      A_DATA:  host_rdata = reply_q;
      A_STAT:  host_rdata = pack_status(flag_q[F_HOST], flag_q[F_MCU]);
      A_ACK:   host_rdata = sys_status;
      default: host_rdata = '0;
    endcase
  end

  AST_WRITE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (!mcu_irq_n && mcu_flags[0])); // R2
  AST_CLR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_clr && !cmd_wr) |=> (mcu_irq_n && !mcu_flags[0])); // R3
  AST_MCU_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_cmd_rd && mcu_dbg && !mcu_clr && !cmd_wr) |=> $stable(mcu_flags[0])); // R4
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_cap |=> (mcu_flags[1] && reply_q == $past(pa_in))); // R5
  AST_HOST_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_dbg && !nmi_trig && !mcu_cap) |=> ($stable(host_nmi) && $stable(mcu_flags[1]))); // R8
  AST_RESET_IRQ: assert property (@(posedge clk)
    !rst_n |=> (mcu_irq_n && !host_nmi && mcu_flags == 2'b00)); // R1
endmodule

// File: tb/tb_mcu_mailbox.sv
`timescale 1ns/1ps
module tb_mcu_mailbox;
  logic       clk = 0, rst_n = 0;
  logic       host_wr = 0, host_rd = 0, host_dbg = 0, nmi_trig = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, sys_status = 8'hA5, pa_in = 0, pa_out;
  logic       host_nmi, pa_oe, mcu_irq_n, mcu_cmd_rd = 0, mcu_dbg = 0;
  logic [3:0] mcu_ctl = 0;
  logic [1:0] mcu_flags;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mcu_mailbox dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick(); host_wr = 0;
  endtask

  task automatic hread(input logic [1:0] a, input logic dbg, output logic [7:0] d);
    host_rd = 1; host_addr = a; host_dbg = dbg; #1 d = host_rdata;
    tick(); host_rd = 0; host_dbg = 0;
  endtask

  task automatic ctl_pulse(input int bitn);
    mcu_ctl[bitn] = 1; #1;
    if (bitn == 2) chk(pa_oe, 0, "R3 oe off");
    tick(); mcu_ctl[bitn] = 0;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    tick(); tick(); rst_n = 1; #1;
    // R1 reset state
    chk(mcu_flags, 0, "R1 flags"); chk(mcu_irq_n, 1, "R1 irq");
    chk(host_nmi, 0, "R1 nmi"); chk(pa_out, 0, "R1 cmd latch");
    hread(0, 1, r); chk(r, 0, "R1 reply latch");

    // R2/R3/R4 sweep over all command bytes
    for (int v = 0; v < 256; v++) begin
      hwrite(0, 8'(v));
      chk(pa_out, v, "R2 data"); chk(pa_oe, 1, "R3 oe on");
      chk(mcu_flags[0], 1, "R2 flag"); chk(mcu_irq_n, 0, "R2 irq");
      hread(1, 0, r); chk(r, 8'h01, "R7 status");
      mcu_cmd_rd = 1; mcu_dbg = 1; tick(); mcu_cmd_rd = 0; mcu_dbg = 0;
      chk(mcu_flags[0], 1, "R4 dbg keeps");
      if (v % 2 == 0) begin
        ctl_pulse(2);
        chk(mcu_flags[0], 0, "R3 clr flag"); chk(mcu_irq_n, 1, "R3 clr irq");
      end else begin
        mcu_cmd_rd = 1; tick(); mcu_cmd_rd = 0;
        chk(mcu_flags[0], 0, "R4 read clr"); chk(mcu_irq_n, 0, "R4 irq kept");
        ctl_pulse(2); chk(mcu_irq_n, 1, "R3 irq clr");
      end
    end

    // R5/R6 sweep over all reply bytes
    for (int v = 0; v < 256; v++) begin
      pa_in = 8'(v); ctl_pulse(3); pa_in = ~8'(v); tick();
      chk(mcu_flags[1], 1, "R5 flag");
      hread(1, 0, r); chk(r, 8'h02, "R7 status mcu");
      hread(0, 1, r); chk(r, v, "R6 dbg data"); chk(mcu_flags[1], 1, "R6 dbg keeps");
      hread(0, 0, r); chk(r, v, "R6 data"); chk(mcu_flags[1], 0, "R6 clr");
    end

    // R8 NMI
    nmi_trig = 1; tick(); nmi_trig = 0; chk(host_nmi, 1, "R8 set");
    hread(2, 1, r); chk(r, 8'hA5, "R8 dbg status"); chk(host_nmi, 1, "R8 dbg keeps");
    sys_status = 8'h3C;
    hread(2, 0, r); chk(r, 8'h3C, "R8 status"); chk(host_nmi, 0, "R8 clr");

    // R9 collisions
    mcu_ctl[2] = 1; hwrite(0, 8'h5A); mcu_ctl[2] = 0;
    chk(mcu_flags[0], 1, "R9 wr vs ctl"); chk(mcu_irq_n, 0, "R9 irq vs ctl");
    mcu_cmd_rd = 1; hwrite(0, 8'h6B); mcu_cmd_rd = 0;
    chk(mcu_flags[0], 1, "R9 wr vs rd"); chk(pa_out, 8'h6B, "R9 data");
    ctl_pulse(2);
    pa_in = 8'h11; mcu_ctl[3] = 1; hread(0, 0, r); mcu_ctl[3] = 0;
    chk(mcu_flags[1], 1, "R9 cap vs rd");
    hread(0, 0, r); chk(r, 8'h11, "R6 after collision");
    nmi_trig = 1; hread(2, 0, r); nmi_trig = 0; chk(host_nmi, 1, "R9 nmi vs ack");
    hread(2, 0, r);

    // R10 ignored writes and unused read
    for (int a = 1; a < 4; a++) begin
      hwrite(2'(a), 8'hC3);
      chk(pa_out, 8'h6B, "R10 latch kept"); chk(mcu_flags[0], 0, "R10 flag kept");
    end
    hread(3, 0, r); chk(r, 0, "R10 read 3");
    hread(3, 0, r); hread(1, 0, r); chk(r, 0, "R7 status idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule